// File: doc/BRIEF.md
# Fast Ethernet Transmit Coding Path

This block turns a stream of 4-bit transmit nibbles into the ternary line state of a 100 Mb/s twisted-pair link. It runs on a single 125 MHz bit clock. An internal divide-by-five marks every fifth cycle as a nibble boundary, and a strobe output tells the source in which cycle the nibble inputs are captured. A frame controller turns enable transitions into start and end delimiters, fills gaps with idle code groups, and replaces data with halt code groups once an error is flagged. Each code group is shifted out most significant bit first. Each bit is whitened by a free-running stream cipher, then passed through a transition code and a three-level code.

The source holds the enable high for the whole frame, preamble included. The first two nibbles of a frame are overwritten by the start delimiter. Dropping the enable closes the frame with a two-symbol end delimiter. The line output drives an external analog transmitter. A copy of the transition-coded bit is brought out as well.

Top module: `fe_pcs_tx`

## Requirements
- R1: While rstN is low, lineState is 2'b00, nrziOut is 0 and nibSample is 0. The first capture happens at the fifth rising edge after rstN goes high.
- R2: nibSample is high in exactly one cycle out of every five. txData, txEn and txErr are captured at the rising edge that ends a cycle with nibSample high. The code group chosen then starts going out in the next cycle.
- R3: Outside a frame, each nibble with txEn low sends idle 11111. txErr has no effect on the line while txEn is low.
- R4: A captured nibble with txEn high outside a frame starts a frame and sends J 11000. The next nibble slot sends K 10001. The data and enable of that slot are ignored.
- R5: From the third slot of a frame, each nibble with txEn high and no error is sent as its data code group: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R6: The first data-slot nibble with txEn low sends T 01101. The following slot sends R 00111 whatever the inputs are. The slot after that is treated as outside a frame.
- R7: A nibble captured with txEn and txErr both high inside a frame marks the frame as errored. In the J or K slot the delimiter is still sent. From then on, every data slot with txEn high sends H 00100, even after txErr falls, until the end delimiter.
- R8: Code groups go out one bit per clock, most significant bit first, with no gap between groups.
- R9: A scrambler of 11 stages s[10:0] is seeded to all ones at reset and advances every cycle. Its key bit is k = s[10]^s[8], after which s becomes {s[9:0], k}. The coded bit is XORed with k to form the NRZ bit.
- R10: nrziOut is registered and toggles after every cycle whose NRZ bit is 1. It holds otherwise.
- R11: lineState steps through zero, plus, zero, minus after every cycle whose NRZ bit is 1 and holds otherwise. The encoding is zero 2'b00, plus 2'b01, minus 2'b11, and 2'b10 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txData | input | 4 | Transmit nibble |
| txEn | input | 1 | Frame enable |
| txErr | input | 1 | Transmit error, qualified by txEn |
| nibSample | output | 1 | High in the cycle whose closing edge captures the nibble inputs |
| nrziOut | output | 1 | Transition-coded bit stream |
| lineState | output | 2 | Ternary line level: 00 zero, 01 plus, 11 minus |

## Verification
The hardest case to reach from the ports is the errored frame. The error indication must persist after txErr drops, and an error raised during a delimiter slot must still take effect on later data. The stimulus raises txErr for a single nibble in mid-frame and again in the start slot, then sends clean data and expects halt groups. Enable pulses of one nibble, and an enable that rises during the end-delimiter slot, probe the delimiter sequencing. Because the line output is scrambled and doubly coded, the scoreboard replays the cipher and both line codes bit by bit from the expected code groups. Any wrong symbol therefore shows up as a line-level miscompare within a few cycles.

// File: rtl/fe_pcs_tx_pkg.sv
package fe_pcs_tx_pkg;

  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  localparam logic [1:0] LINE_ZERO  = 2'b00;
  localparam logic [1:0] LINE_PLUS  = 2'b01;
  localparam logic [1:0] LINE_MINUS = 2'b11;

  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CG_H    = 5'b00100;

  typedef enum logic [2:0] {
    SYM_IDLE,
    SYM_J,
    SYM_K,
    SYM_T,
    SYM_R,
    SYM_H,
    SYM_DATA
  } symKind_e;

  typedef struct packed {
    logic             load;
    symKind_e         kind;
    logic [NIB_W-1:0] nib;
  } txStrobe_t;

  function automatic logic [SYM_W-1:0] nibToGroup(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] g;
    case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/fe_pcs_tx_ctrl.sv
module fe_pcs_tx_ctrl
  import fe_pcs_tx_pkg::*;
#(
  parameter int SYM_PERIOD = SYM_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIB_W-1:0] txData,
  input  logic             txEn,
  input  logic             txErr,
  output txStrobe_t        strobe,
  output logic             nibTick
);

  localparam int CNT_W = (SYM_PERIOD > 1) ? $clog2(SYM_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYM_PERIOD - 1);

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_KSLOT,
    FR_DATA,
    FR_RSLOT
  } frame_e;

  logic [CNT_W-1:0] bitCnt;
  frame_e           frState, frNext;
  logic             errSticky, errNext;
  symKind_e         kindSel;
  logic             tick;
  logic             errHit;

  assign tick   = (bitCnt == CNT_LAST);
  assign errHit = txEn & txErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (tick) begin
      bitCnt <= '0;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    frNext  = frState;
    errNext = errSticky;
    kindSel = SYM_IDLE;
    case (frState)
      FR_IDLE: begin
        if (txEn) begin
          kindSel = SYM_J;
          frNext  = FR_KSLOT;
          errNext = errHit;
        end else begin
          kindSel = SYM_IDLE;
          errNext = 1'b0;
        end
      end
      FR_KSLOT: begin
        kindSel = SYM_K;
        frNext  = FR_DATA;
        errNext = errSticky | errHit;
      end
      FR_DATA: begin
        if (!txEn) begin
          kindSel = SYM_T;
          frNext  = FR_RSLOT;
          errNext = 1'b0;
        end else if (errSticky || txErr) begin
          kindSel = SYM_H;
          errNext = 1'b1;
        end else begin
          kindSel = SYM_DATA;
        end
      end
      default: begin
        kindSel = SYM_R;
        frNext  = FR_IDLE;
        errNext = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frState   <= FR_IDLE;
      errSticky <= 1'b0;
    end else if (tick) begin
      frState   <= frNext;
      errSticky <= errNext;
    end
  end

  assign strobe.load = tick;
  assign strobe.kind = kindSel;
  assign strobe.nib  = txData;
  assign nibTick     = tick;

endmodule

// File: rtl/fe_pcs_tx_dp.sv
module fe_pcs_tx_dp
  import fe_pcs_tx_pkg::*;
#(
  parameter int              LFSR_LEN  = 11,
  parameter int              LFSR_TAP  = 9,
  parameter logic [LFSR_LEN-1:0] LFSR_SEED = '1
) (
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t strobe,
  output logic      nrziOut,
  output logic [1:0] lineState
);

  localparam int TAP_IDX = LFSR_TAP - 1;
  localparam int TOP_IDX = LFSR_LEN - 1;

  logic [SYM_W-1:0]    groupSel;
  logic [SYM_W-1:0]    shReg;
  logic [LFSR_LEN-1:0] lfsr;
  logic                keyBit;
  logic                serBit;
  logic                nrzBit;
  logic                nrziReg;
  logic [1:0]          mltPhase;

  // symbol selection
  always_comb begin
    case (strobe.kind)
      SYM_J:    groupSel = CG_J;
      SYM_K:    groupSel = CG_K;
      SYM_T:    groupSel = CG_T;
      SYM_R:    groupSel = CG_R;
      SYM_H:    groupSel = CG_H;
      SYM_DATA: groupSel = nibToGroup(strobe.nib);
      default:  groupSel = CG_IDLE;
    endcase
  end

  // serializer, msb first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= CG_IDLE;
    end else if (strobe.load) begin
      shReg <= groupSel;
    end else begin
      shReg <= {shReg[SYM_W-2:0], 1'b0};
    end
  end

  assign serBit = shReg[SYM_W-1];

  // stream cipher
  assign keyBit = lfsr[TOP_IDX] ^ lfsr[TAP_IDX];
  assign nrzBit = serBit ^ keyBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= LFSR_SEED;
    end else begin
      lfsr <= {lfsr[TOP_IDX-1:0], keyBit};
    end
  end

  // transition coding and three-level coding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nrziReg  <= 1'b0;
      mltPhase <= 2'd0;
    end else begin
      nrziReg  <= nrziReg ^ nrzBit;
      mltPhase <= mltPhase + {1'b0, nrzBit};
    end
  end

  always_comb begin
    case (mltPhase)
      2'd1:    lineState = LINE_PLUS;
      2'd3:    lineState = LINE_MINUS;
      default: lineState = LINE_ZERO;
    endcase
  end

  assign nrziOut = nrziReg;

endmodule

// File: rtl/fe_pcs_tx.sv
module fe_pcs_tx
  import fe_pcs_tx_pkg::*;
#(
  parameter int SYM_PERIOD = SYM_W,
  parameter int LFSR_LEN   = 11,
  parameter int LFSR_TAP   = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] txData,
  input  logic       txEn,
  input  logic       txErr,
  output logic       nibSample,
  output logic       nrziOut,
  output logic [1:0] lineState
);

  txStrobe_t ctl;

  fe_pcs_tx_ctrl #(
    .SYM_PERIOD(SYM_PERIOD)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .txData (txData),
    .txEn   (txEn),
    .txErr  (txErr),
    .strobe (ctl),
    .nibTick(nibSample)
  );

  fe_pcs_tx_dp #(
    .LFSR_LEN (LFSR_LEN),
    .LFSR_TAP (LFSR_TAP),
    .LFSR_SEED('1)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (ctl),
    .nrziOut  (nrziOut),
    .lineState(lineState)
  );

endmodule

// File: rtl/fe_pcs_tx_chk.sv
module fe_pcs_tx_chk
  import fe_pcs_tx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       txEn,
  input logic       txErr,
  input logic       nibSample,
  input logic       nrziOut,
  input logic [1:0] lineState,
  input txStrobe_t  ctl
);

  logic [2:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (nibSample) begin
      gapCnt <= '0;
    end else begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  AST_LINE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    lineState != 2'b10); // R11

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    nibSample |-> gapCnt == 3'd4); // R2

  AST_TICK_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    !nibSample |-> gapCnt < 3'd4); // R2

  AST_NRZI_MLT_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((nrziOut != $past(nrziOut)) == (lineState != $past(lineState)))); // R10

  AST_MLT_NO_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> !(($past(lineState) == LINE_PLUS && lineState == LINE_MINUS) ||
               ($past(lineState) == LINE_MINUS && lineState == LINE_PLUS))); // R11

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (nibSample && txEn && txErr) |-> ctl.kind != SYM_DATA); // R7

  AST_QUIET_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    (nibSample && !txEn) |-> (ctl.kind != SYM_DATA && ctl.kind != SYM_H)); // R3

endmodule

bind fe_pcs_tx fe_pcs_tx_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .txEn     (txEn),
  .txErr    (txErr),
  .nibSample(nibSample),
  .nrziOut  (nrziOut),
  .lineState(lineState),
  .ctl      (ctl)
);

// File: tb/tb_fe_pcs_tx.sv
`timescale 1ns/1ps
module tb_fe_pcs_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] txData = 4'h0;
  logic       txEn = 1'b0;
  logic       txErr = 1'b0;
  logic       nibSample;
  logic       nrziOut;
  logic [1:0] lineState;

  int    vecCnt = 0;
  int    missCnt = 0;
  bit    run = 1'b0;
  bit    done = 1'b0;
  string curReq = "R3";

  logic [4:0] expQ[$];

  int   bState = 0;
  bit   bSticky = 1'b0;

  always #4 clk = ~clk;

  fe_pcs_tx dut (
    .clk      (clk),
    .rstN     (rstN),
    .txData   (txData),
    .txEn     (txEn),
    .txErr    (txErr),
    .nibSample(nibSample),
    .nrziOut  (nrziOut),
    .lineState(lineState)
  );

  // R5 table
  function automatic logic [4:0] dataGroup(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001;
      4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011;
      4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011;
      4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  // driver: waits for the capture cycle, applies a nibble, pushes the expected group
  task automatic sendNibble(input bit en, input bit er, input logic [3:0] d);
    logic [4:0] g;
    do @(negedge clk); while (!nibSample);
    txEn = en; txErr = er; txData = d;
    case (bState)
      0: if (en) begin g = 5'b11000; bSticky = er; bState = 1; end   // R4 J
         else g = 5'b11111;                                          // R3 idle
      1: begin g = 5'b10001; if (en && er) bSticky = 1'b1; bState = 2; end // R4 K
      2: if (!en) begin g = 5'b01101; bSticky = 1'b0; bState = 3; end // R6 T
         else if (er || bSticky) begin g = 5'b00100; bSticky = 1'b1; end // R7 H
         else g = dataGroup(d);
      default: begin g = 5'b00111; bState = 0; end                  // R6 R
    endcase
    expQ.push_back(g);
  endtask

  // monitor: replays serializer (R8), cipher (R9), NRZI (R10), MLT-3 (R11)
  initial begin : monitor
    logic [4:0]  mCode;
    int          mIdx;
    logic [10:0] mS;
    logic        mNrzi;
    logic [1:0]  mPh;
    logic        b, k, z;
    logic [1:0]  expLine;
    mCode = 5'b11111; mIdx = 0; mS = 11'h7FF; mNrzi = 1'b0; mPh = 2'd0;
    forever begin
      @(posedge clk);
      if (run) begin
        b = mCode[4 - mIdx];
        k = mS[10] ^ mS[8];
        z = b ^ k;
        mS = {mS[9:0], k};
        mNrzi = mNrzi ^ z;
        mPh = mPh + {1'b0, z};
        mIdx++;
        if (mIdx == 5) begin
          mIdx = 0;
          if (expQ.size() == 0) begin
            missCnt++;
            $display("FAIL R2 no nibble captured: actual empty expected group");
            mCode = 5'b11111;
          end else begin
            mCode = expQ.pop_front();
          end
        end
        expLine = (mPh == 2'd1) ? 2'b01 : (mPh == 2'd3) ? 2'b11 : 2'b00;
        @(negedge clk);
        vecCnt++;
        if (lineState !== expLine) begin
          missCnt++;
          $display("FAIL %s/R11 lineState actual %b expected %b", curReq, lineState, expLine);
        end
        vecCnt++;
        if (nrziOut !== mNrzi) begin
          missCnt++;
          $display("FAIL %s/R10 nrziOut actual %b expected %b", curReq, nrziOut, mNrzi);
        end
        vecCnt++;
        if (nibSample !== (mIdx == 4)) begin
          missCnt++;
          $display("FAIL R2 nibSample actual %b expected %b", nibSample, (mIdx == 4));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      missCnt++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

  initial begin : stim
    // R1 reset state
    repeat (3) @(negedge clk);
    vecCnt++;
    if (lineState !== 2'b00 || nrziOut !== 1'b0 || nibSample !== 1'b0) begin
      missCnt++;
      $display("FAIL R1 reset outputs actual %b/%b/%b expected 00/0/0",
               lineState, nrziOut, nibSample);
    end
    rstN = 1'b1;
    run  = 1'b1;

    // R3 idle, with txErr toggling while txEn low
    curReq = "R3";
    for (int i = 0; i < 8; i++) sendNibble(1'b0, i[0], 4'(i));

    // R4/R5/R6 full frame with every nibble value
    curReq = "R5";
    sendNibble(1'b1, 1'b0, 4'h5);
    sendNibble(1'b1, 1'b0, 4'h5);
    for (int i = 0; i < 16; i++) sendNibble(1'b1, 1'b0, 4'(i));
    curReq = "R6";
    sendNibble(1'b0, 1'b0, 4'h0);
    sendNibble(1'b0, 1'b0, 4'h0);
    sendNibble(1'b0, 1'b0, 4'h0);

    // R7 error for one nibble mid-frame, sticky afterwards
    curReq = "R7";
    sendNibble(1'b1, 1'b0, 4'h5);
    sendNibble(1'b1, 1'b0, 4'h5);
    sendNibble(1'b1, 1'b0, 4'hA);
    sendNibble(1'b1, 1'b1, 4'h3);
    for (int i = 0; i < 4; i++) sendNibble(1'b1, 1'b0, 4'(i + 6));
    sendNibble(1'b0, 1'b0, 4'h0);
    sendNibble(1'b0, 1'b0, 4'h0);

    // R7 error raised in the start slot only
    sendNibble(1'b1, 1'b1, 4'h5);
    sendNibble(1'b1, 1'b0, 4'h5);
    sendNibble(1'b1, 1'b0, 4'h1);
    sendNibble(1'b1, 1'b0, 4'h2);
    sendNibble(1'b0, 1'b1, 4'h0);
    sendNibble(1'b0, 1'b0, 4'h0);
    // fresh frame after errored one is clean
    sendNibble(1'b1, 1'b0, 4'h5);
    sendNibble(1'b1, 1'b0, 4'h5);
    sendNibble(1'b1, 1'b0, 4'hC);
    sendNibble(1'b0, 1'b0, 4'h0);

    // R4/R6 one-nibble enable pulse, and enable rising in the R slot
    curReq = "R4";
    sendNibble(1'b0, 1'b0, 4'h0);
    sendNibble(1'b0, 1'b0, 4'h0);
    sendNibble(1'b1, 1'b0, 4'h9);
    sendNibble(1'b0, 1'b0, 4'h9);
    sendNibble(1'b0, 1'b0, 4'h9);
    sendNibble(1'b1, 1'b1, 4'h9);
    sendNibble(1'b1, 1'b0, 4'h7);
    sendNibble(1'b1, 1'b0, 4'h7);
    sendNibble(1'b1, 1'b0, 4'hE);
    sendNibble(1'b0, 1'b0, 4'h0);
    sendNibble(1'b0, 1'b0, 4'h0);

    // R9 long idle run exercises the cipher sequence
    curReq = "R9";
    for (int i = 0; i < 450; i++) sendNibble(1'b0, 1'b0, 4'h0);

    repeat (3) @(negedge clk);
    run  = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule